// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block sits between nine asynchronous interrupt pins and the interrupt logic of a processor. One pin is a non-maskable request. The other eight are maskable request lines, numbered 0 to 7. Each pin passes through a two-flop synchronizer. The block then either follows the pin's low level or latches an edge into a sticky flag, depending on a per-line mode chosen by software. The non-maskable line always latches. Software picks whether it reacts to a rising edge or a falling edge.

Software uses a small register port with two locations. Address 0 is the 16-bit control register. It holds the non-maskable edge polarity and the eight sense modes, and it shows the live synchronized level of the non-maskable pin. Address 1 is a status view of the request outputs. Writing 1 to a bit at address 1 clears the matching latched flag. Reads return their data in the same cycle. A reset restores the control fields. The block has no standby input, so nothing but a reset or a write alters the register.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all writable control fields are 0, every request output is low while the pins stay high, and a control read returns 0x8000 with the non-maskable pin high.
- R2: Control bit 15 reads the synchronized non-maskable pin level, 1 for high. Writes to that bit have no effect.
- R3: Control bits 14 down to 9 read 0 whatever value is written to them.
- R4: With control bit 8 at 0, a falling edge on the non-maskable pin latches `nmi_req`.
- R5: With control bit 8 at 1, a rising edge latches `nmi_req` and a falling edge does not.
- R6: The sense-mode bit of maskable line i sits at control bit 7-i. The status bit of line i sits at status bit 7-i, and `nmi_req` appears at status bit 8. Status bits 15 down to 9 read 0.
- R7: A mode bit of 0 selects level sensing. `irq_req[i]` is then high exactly while the synchronized pin is low, and nothing is latched.
- R8: A mode bit of 1 selects falling-edge sensing. A latched flag drives the output until a 1 is written to its status bit. Writing 0 to a status bit, or 1 to a different status bit, leaves the flag set.
- R9: When an edge is detected in the same cycle as a clear write to its status bit, the flag stays set.
- R10: A control write that changes a line's mode bit clears that line's pending latched flag.
- R11: A level request appears in the output two clock edges after the pin changes. A latched request appears three clock edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control register, 1 = status / clear register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the access |
| nmi_pin | input | 1 | Non-maskable interrupt pin, asynchronous |
| irq_pin | input | 8 | Maskable interrupt pins, bit i = line i, asynchronous |
| nmi_req | output | 1 | Latched non-maskable request |
| irq_req | output | 8 | Maskable requests, bit i = line i |

## Verification
A bad synchronizer or edge-history state appears as a request output that arrives one edge early or late. It can also appear as an edge that never sets its flag, which the bench sees within three clocks of a pin change. A flag stuck in the wrong state shows up in two ways. It either fails to hold after the pin returns to idle, or it survives a clear or mode change, and the next output sample shows it. A wrong bit mapping in the control or status register shows in the same-cycle read data. It also shows as a different line responding to a pin change.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W       = 16;
  localparam int N_IRQ       = 8;
  localparam int NMI_LVL_BIT = 15;
  localparam int NMI_POL_BIT = 8;
  localparam int RSV_HI      = 14;
  localparam int RSV_LO      = 9;

  typedef enum logic {
    LOC_CTRL = 1'b0,
    LOC_STAT = 1'b1
  } reg_loc_e;
endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/eis_line.sv
module eis_line #(
  parameter bit LEVEL_OK = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic edge_mode,
  input  logic rise_sel,
  input  logic clr,
  input  logic mode_chg,
  output logic req
);
  logic prev_q;
  logic flag_q, flag_d, flag_en;
  logic fall_det, rise_det, hit, set;

  // edge history
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= pin_s;
  end

  always_comb begin
    fall_det = prev_q & ~pin_s;
    rise_det = ~prev_q & pin_s;
    hit      = rise_sel ? rise_det : fall_det;
    set      = edge_mode & hit & ~mode_chg;
    flag_en  = set | clr;
    flag_d   = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  generate
    if (LEVEL_OK) begin : g_lvl
      assign req = edge_mode ? flag_q : ~pin_s;
    end else begin : g_edge_only
      assign req = flag_q;
    end
  endgenerate

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr |=> flag_q);
  p_no_spont_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_q && !(edge_mode && hit) |=> !flag_q);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode && hit && clr && !mode_chg |=> flag_q);
  p_modechg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !flag_q);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             nmi_pin,
  input  logic [N_IRQ-1:0] irq_pin,
  output logic             nmi_req,
  output logic [N_IRQ-1:0] irq_req
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  // pin synchronizers, bit N_IRQ carries the non-maskable pin
  logic [N_IRQ:0] pins_s;
  eis_sync #(.W(N_IRQ + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in ({nmi_pin, irq_pin}),
    .sync_out (pins_s)
  );

  // control register
  logic             pol_q, pol_d;
  logic [N_IRQ-1:0] mode_q, mode_d;
  logic             wr_ctrl, wr_stat;
  logic [N_IRQ-1:0] mode_chg, irq_clr;
  logic             nmi_clr;

  always_comb begin
    wr_ctrl = bus_sel & bus_we & (bus_addr == LOC_CTRL);
    wr_stat = bus_sel & bus_we & (bus_addr == LOC_STAT);
    pol_d   = bus_wdata[NMI_POL_BIT];
    nmi_clr = wr_stat & bus_wdata[NMI_POL_BIT];
    for (int i = 0; i < N_IRQ; i++) begin
      mode_d[i]   = bus_wdata[N_IRQ-1-i];
      mode_chg[i] = wr_ctrl & (mode_d[i] != mode_q[i]);
      irq_clr[i]  = wr_stat & bus_wdata[N_IRQ-1-i];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      pol_q  <= 1'b0;
      mode_q <= '0;
    end else if (wr_ctrl) begin
      pol_q  <= pol_d;
      mode_q <= mode_d;
    end
  end

  // detection per line
  eis_line #(.LEVEL_OK(1'b0)) u_nmi (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .pin_s     (pins_s[N_IRQ]),
    .edge_mode (1'b1),
    .rise_sel  (pol_q),
    .clr       (nmi_clr),
    .mode_chg  (1'b0),
    .req       (nmi_req)
  );

  generate
    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      eis_line #(.LEVEL_OK(1'b1)) u_line (
        .clk       (clk),
        .rst_n     (rst_core_n),
        .pin_s     (pins_s[i]),
        .edge_mode (mode_q[i]),
        .rise_sel  (1'b0),
        .clr       (irq_clr[i] | mode_chg[i]),
        .mode_chg  (mode_chg[i]),
        .req       (irq_req[i])
      );
    end
  endgenerate

  // same-cycle read
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == LOC_CTRL) begin
      bus_rdata[NMI_LVL_BIT] = pins_s[N_IRQ];
      bus_rdata[NMI_POL_BIT] = pol_q;
      for (int i = 0; i < N_IRQ; i++) bus_rdata[N_IRQ-1-i] = mode_q[i];
    end else begin
      bus_rdata[NMI_POL_BIT] = nmi_req;
      for (int i = 0; i < N_IRQ; i++) bus_rdata[N_IRQ-1-i] = irq_req[i];
    end
  end

  p_resv_zero_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_rdata[RSV_HI:RSV_LO] == '0);
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    !wr_ctrl |=> $stable({pol_q, mode_q}));
  p_lvl_live_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    bus_addr == LOC_CTRL |-> bus_rdata[NMI_LVL_BIT] == pins_s[N_IRQ]);
  p_nmi_clear_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    nmi_req && !nmi_clr |=> nmi_req);
endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we, bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        nmi_pin;
  logic [7:0]  irq_pin;
  logic        nmi_req;
  logic [7:0]  irq_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nmi_pin(nmi_pin), .irq_pin(irq_pin), .nmi_req(nmi_req), .irq_req(irq_req)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 nmi_req, 2 irq_req
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // monitor: compares queued expectations mid-low-phase
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = bus_rdata;
          1:       act = {15'd0, nmi_req};
          default: act = {8'd0, irq_req};
        endcase
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int kind, input logic addr, input logic [15:0] exp, input string tag);
    item_t it;
    if (kind == 0) begin
      bus_sel  = 1'b1;
      bus_we   = 1'b0;
      bus_addr = addr;
    end
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic addr, input logic [15:0] data);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 1'b0;
    bus_wdata = '0; nmi_pin = 1'b1; irq_pin = 8'hFF;
    step(3);
    rst_n = 1'b1;
    step(5);

    // R1 reset state
    chk(0, 1'b0, 16'h8000, "R1 ctrl after reset"); chk(1, 0, 16'h0, "R1 nmi_req");
    chk(2, 0, 16'h0, "R1 irq_req"); step(1);
    chk(0, 1'b1, 16'h0000, "R1 status after reset"); step(1);

    // R2/R3 read-only and reserved bits
    wr(1'b0, 16'hFFFF); chk(0, 1'b0, 16'h81FF, "R3 reserved read 0"); step(1);
    wr(1'b0, 16'h7E00); chk(0, 1'b0, 16'h8000, "R2 level bit not writable"); step(1);

    // R4 falling edge, R2 live level, R11 latency
    nmi_pin = 1'b0; step(2);
    chk(0, 1'b0, 16'h0000, "R2 live level low"); chk(1, 0, 16'h0, "R11 nmi not yet"); step(1);
    chk(1, 0, 16'h1, "R4 falling edge latched"); step(1);
    chk(0, 1'b1, 16'h0100, "R6 status nmi bit"); step(1);
    nmi_pin = 1'b1; step(3);
    chk(1, 0, 16'h1, "R8 nmi held");
    wr(1'b1, 16'h0100); chk(1, 0, 16'h0, "R8 nmi cleared"); step(1);

    // R5 rising polarity
    wr(1'b0, 16'h0100); step(1);
    nmi_pin = 1'b0; step(4);
    chk(1, 0, 16'h0, "R5 falling ignored");
    nmi_pin = 1'b1; step(3);
    chk(1, 0, 16'h1, "R5 rising latched");
    wr(1'b1, 16'h0100); chk(1, 0, 16'h0, "R5 cleared");

    // R9 edge and clear in the same cycle
    nmi_pin = 1'b0; step(4);
    nmi_pin = 1'b1; step(2);
    wr(1'b1, 16'h0100); chk(1, 0, 16'h1, "R9 edge beats clear"); step(1);
    wr(1'b1, 16'h0100); chk(1, 0, 16'h0, "R9 later clear"); step(1);
    wr(1'b0, 16'h0000); step(1);

    // R7 level mode, R11 latency
    irq_pin[2] = 1'b0; step(1);
    chk(2, 0, 16'h00, "R11 level not yet"); step(1);
    chk(2, 0, 16'h04, "R7 level request"); step(1);
    chk(0, 1'b1, 16'h0020, "R6 status line 2 at bit 5"); step(1);
    irq_pin[2] = 1'b1; step(2);
    chk(2, 0, 16'h00, "R7 level not latched"); step(1);

    // R6 mapping, R8 edge latch and clear
    wr(1'b0, 16'h0004); chk(0, 1'b0, 16'h8004, "R6 ctrl line 5 at bit 2"); step(1);
    irq_pin[5] = 1'b0; step(2);
    chk(2, 0, 16'h00, "R11 edge not yet"); step(1);
    chk(2, 0, 16'h20, "R8 edge latched line 5");
    irq_pin[5] = 1'b1; step(3);
    chk(2, 0, 16'h20, "R8 held after pin idle");
    wr(1'b1, 16'h0001); chk(2, 0, 16'h20, "R8 other bit clear ignored"); step(1);
    wr(1'b1, 16'h0004); chk(2, 0, 16'h00, "R8 line 5 cleared"); step(1);

    // R10 mode change clears pending flag
    irq_pin[5] = 1'b0; step(3);
    irq_pin[5] = 1'b1; step(3);
    chk(2, 0, 16'h20, "R10 pending before change");
    wr(1'b0, 16'h0000); chk(2, 0, 16'h00, "R10 level after change"); step(1);
    wr(1'b0, 16'h0004); chk(2, 0, 16'h00, "R10 flag gone"); step(1);

    // R1 reset restores control
    wr(1'b0, 16'h01FF); step(1);
    rst_n = 1'b0; step(2);
    rst_n = 1'b1; step(4);
    chk(0, 1'b0, 16'h8000, "R1 ctrl after second reset"); step(1);
    chk(0, 1'b1, 16'h0000, "R1 status after second reset"); step(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule